// File: doc/BRIEF.md
# Dual-Queue Conversion Command Scheduler

This block feeds conversion commands from two command lists to one shared analog converter. Each list is held in an internal register array and is walked from its first entry. For each entry the block sends a start pulse with a channel number and waits for the converter's done pulse before it moves on. A pass ends at an entry that carries an end-of-list bit, or at the last array slot. A pass also halts at an entry that carries a pause bit. In that case the next trigger resumes the list at the entry after the paused one.

Queue 1 outranks queue 2. A queue 1 trigger that arrives while queue 2 owns the converter cancels the conversion in flight and suspends queue 2. When queue 1 goes idle or pauses, queue 2 runs the cancelled entry again from its start. A queue 2 trigger that arrives while queue 1 is active is held as pending. Either queue can be started by a rising edge on its external trigger, by a single-scan software pulse, or by the end of its previous pass in continuous mode. Queue 2 also accepts a timer pulse. Completion, pause and overrun flags are sticky per queue, and one 4-bit code reports both queue states.

Top module: `qcmd_sched`

## Requirements
- R1: After reset, qstat is 0000, every flag is 0, conv_start and conv_abort are 0, and all command slots read as zero.
- R2: A command word holds the channel in bits [CH_W-1:0], the pause bit at CH_W and the end-of-list bit at CH_W+1. A triggered pass issues one conv_start per entry, in index order, with conv_chan equal to that entry's channel. It holds each entry until conv_done arrives. The pass ends after the end-of-list entry or slot DEPTH-1, sets the queue's completion flag and rewinds to slot 0.
- R3: An external trigger starts a pass only on a rising edge. A level held high starts no further pass.
- R4: A one-cycle timer pulse triggers queue 2 in the same way as its software pulse.
- R5: After an entry with the pause bit completes, the queue stops with its pause flag set and enters the paused state. The next trigger resumes at the following entry.
- R6: A queue 1 trigger during a queue 2 conversion pulses conv_abort and suspends queue 2. Queue 1 then runs its pass. Afterwards queue 2 re-issues the cancelled entry's channel and finishes its own pass. The two queues are never active together.
- R7: A queue 2 trigger while queue 1 is active leaves queue 2 pending. Queue 1 keeps the converter until its pass ends, and queue 2 starts afterwards.
- R8: A trigger for a queue that is active, pending or suspended sets that queue's overrun flag. It does not restart or alter the pass in progress.
- R9: In continuous mode the end of a pass sets the completion flag and restarts the list at slot 0 with no new trigger and no overrun.
- R10: Flags are sticky until the matching clear input is pulsed. A set and a clear in the same cycle leave the flag set.
- R11: Triggers on a queue whose enable is low start nothing and set no flag.
- R12: qstat = {Q1 code, Q2 code}. The Q1 code is 00 for idle, 01 for paused and 10 for active. When queue 1 is not active, the Q2 code is 00 for idle, 01 for active, 10 for paused and 11 for pending or about to resume. When queue 1 is active, the Q2 code is 00 for idle, 01 for paused, 10 for suspended and 11 for pending. Codes 0011 and 0111 never last more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_en | input | 2 | Per-queue trigger enable (bit 0 queue 1, bit 1 queue 2) |
| q_cont | input | 2 | Per-queue continuous mode |
| ext_trig | input | 2 | Per-queue external trigger level, rising edge acts |
| sw_trig | input | 2 | Per-queue single-scan software pulse |
| tmr_trig | input | 1 | Queue 2 timer expiry pulse |
| cmd_we | input | 1 | Command slot write strobe |
| cmd_wq | input | 1 | Target queue of the write (0 queue 1, 1 queue 2) |
| cmd_widx | input | IDX_W | Slot index of the write |
| cmd_wdata | input | CH_W+2 | Command word written |
| conv_done | input | 1 | Converter finished the current conversion |
| conv_start | output | 1 | One-cycle start request to the converter |
| conv_chan | output | CH_W | Channel of the current conversion |
| conv_abort | output | 1 | One-cycle cancel of the conversion in flight |
| cf | output | 2 | Sticky completion flags |
| pf | output | 2 | Sticky pause flags |
| tor | output | 2 | Sticky trigger overrun flags |
| clr_cf | input | 2 | Write-one clear of cf |
| clr_pf | input | 2 | Write-one clear of pf |
| clr_tor | input | 2 | Write-one clear of tor |
| qstat | output | 4 | Combined queue state code |

## Verification
The hardest state to reach is preemption in the middle of a conversion. The bench must land a queue 1 trigger while queue 2 has a start outstanding and no done has come back. It must then see that the same channel is issued again once queue 1 lets go. The bench plays the converter itself and withholds conv_done after queue 2's first start. It fires the queue 1 software pulse in that window and checks the cancel pulse and the suspended code. Next it serves queue 1 and watches the one-cycle 0011 code before queue 2 repeats the cancelled channel. The transient codes are sampled on the exact cycle after the triggering edge.

// File: rtl/qcmd_pkg.sv
package qcmd_pkg;

   typedef enum logic [2:0] {
      QS_IDLE    = 3'd0,
      QS_ACTIVE  = 3'd1,
      QS_PAUSED  = 3'd2,
      QS_PENDING = 3'd3,
      QS_SUSP    = 3'd4
   } qstate_e;

   // combined status: upper pair for queue 1, lower pair for queue 2
   function automatic logic [3:0] encode_status(qstate_e s1, qstate_e s2);
      logic [1:0] hi;
      logic [1:0] lo;
      case (s1)
         QS_PAUSED: hi = 2'b01;
         QS_ACTIVE: hi = 2'b10;
         default:   hi = 2'b00;
      endcase
      if (s1 == QS_ACTIVE) begin
         case (s2)
            QS_PAUSED:  lo = 2'b01;
            QS_SUSP:    lo = 2'b10;
            QS_PENDING: lo = 2'b11;
            default:    lo = 2'b00;
         endcase
      end else begin
         case (s2)
            QS_ACTIVE:  lo = 2'b01;
            QS_PAUSED:  lo = 2'b10;
            QS_PENDING: lo = 2'b11;
            QS_SUSP:    lo = 2'b11;
            default:    lo = 2'b00;
         endcase
      end
      return {hi, lo};
   endfunction

endpackage

// File: rtl/qcmd_trig.sv
module qcmd_trig #(
   parameter bit HAS_TMR = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic ext,
   input  logic sw,
   input  logic tmr,
   output logic go
);
   logic ext_d;
   logic ext_rise;
   logic tmr_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) ext_d <= 1'b0;
      else        ext_d <= ext;
   end

   assign ext_rise = ext & ~ext_d;

   generate
      if (HAS_TMR) begin : g_tmr
         assign tmr_hit = tmr;
      end else begin : g_no_tmr
         assign tmr_hit = tmr & 1'b0;
      end
   endgenerate

   assign go = en & (ext_rise | sw | tmr_hit);

endmodule

// File: rtl/qcmd_store.sv
module qcmd_store #(
   parameter int DEPTH = 8,
   parameter int CMD_W = 8,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             wq,
   input  logic [IDX_W-1:0] widx,
   input  logic [CMD_W-1:0] wdata,
   input  logic [IDX_W-1:0] rptr1,
   input  logic [IDX_W-1:0] rptr2,
   output logic [CMD_W-1:0] rdata1,
   output logic [CMD_W-1:0] rdata2
);
   logic [CMD_W-1:0] rd [2];

   generate
      for (genvar q = 0; q < 2; q++) begin : g_q
         logic [CMD_W-1:0] mem [DEPTH];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we && (wq == q[0])) begin
               mem[widx] <= wdata;
            end
         end
         assign rd[q] = mem[(q == 0) ? rptr1 : rptr2];
      end
   endgenerate

   assign rdata1 = rd[0];
   assign rdata2 = rd[1];

endmodule

// File: rtl/qcmd_flags.sv
module qcmd_flags #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= (q & ~clr) | set;
   end
endmodule

// File: rtl/qcmd_seq.sv
module qcmd_seq
   import qcmd_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CH_W  = 6,
   localparam int CMD_W = CH_W + 2,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go1,
   input  logic             go2,
   input  logic [1:0]       cont,
   input  logic             done,
   input  logic [CMD_W-1:0] cmd1,
   input  logic [CMD_W-1:0] cmd2,
   output logic [IDX_W-1:0] ptr1,
   output logic [IDX_W-1:0] ptr2,
   output logic             start,
   output logic [CH_W-1:0]  chan,
   output logic             abort,
   output logic [1:0]       set_cf,
   output logic [1:0]       set_pf,
   output logic [1:0]       set_tor,
   output qstate_e          q1_st,
   output qstate_e          q2_st
);
   localparam int PZ_BIT  = CH_W;
   localparam int EOL_BIT = CH_W + 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic busy;
   logic own;          // 0: queue 1 holds the converter, 1: queue 2
   logic q1_takes;
   logic q2_gate;
   logic abort_now;
   logic fin;
   logic [CMD_W-1:0] cur;
   logic cur_last;
   logic cur_pz;

   assign q1_takes  = go1 && (q1_st != QS_ACTIVE);
   assign q2_gate   = (q1_st != QS_ACTIVE) && !q1_takes;
   assign abort_now = q1_takes && busy && own;
   assign fin       = busy && done && !abort_now;
   assign cur       = own ? cmd2 : cmd1;
   assign cur_pz    = cur[PZ_BIT];
   assign cur_last  = cur[EOL_BIT] || ((own ? ptr2 : ptr1) == LAST);

   assign set_tor[0] = go1 && (q1_st == QS_ACTIVE);
   assign set_tor[1] = go2 && ((q2_st == QS_ACTIVE) || (q2_st == QS_PENDING) ||
                               (q2_st == QS_SUSP));
   assign set_cf[0]  = fin && !own && cur_last;
   assign set_cf[1]  = fin &&  own && cur_last;
   assign set_pf[0]  = fin && !own && cur_pz;
   assign set_pf[1]  = fin &&  own && cur_pz;

   // queue 1 state and pointer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q1_st <= QS_IDLE;
         ptr1  <= '0;
      end else if (q1_takes) begin
         q1_st <= QS_ACTIVE;
      end else if (fin && !own) begin
         if (cur_last) begin
            ptr1  <= '0;
            q1_st <= cont[0] ? QS_ACTIVE : QS_IDLE;
         end else if (cur_pz) begin
            ptr1  <= ptr1 + 1'b1;
            q1_st <= QS_PAUSED;
         end else begin
            ptr1  <= ptr1 + 1'b1;
         end
      end
   end

   // queue 2 state and pointer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q2_st <= QS_IDLE;
         ptr2  <= '0;
      end else begin
         case (q2_st)
            QS_IDLE, QS_PAUSED: begin
               if (go2) q2_st <= QS_PENDING;
            end
            QS_PENDING, QS_SUSP: begin
               if (q2_gate) q2_st <= QS_ACTIVE;
            end
            QS_ACTIVE: begin
               if (q1_takes) begin
                  q2_st <= QS_SUSP;
               end else if (fin && own) begin
                  if (cur_last) begin
                     ptr2  <= '0;
                     q2_st <= cont[1] ? QS_ACTIVE : QS_IDLE;
                  end else if (cur_pz) begin
                     ptr2  <= ptr2 + 1'b1;
                     q2_st <= QS_PAUSED;
                  end else begin
                     ptr2  <= ptr2 + 1'b1;
                  end
               end
            end
            default: q2_st <= QS_IDLE;
         endcase
      end
   end

   // converter handshake
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         own   <= 1'b0;
         start <= 1'b0;
         abort <= 1'b0;
         chan  <= '0;
      end else begin
         start <= 1'b0;
         abort <= 1'b0;
         if (abort_now) begin
            busy  <= 1'b0;
            abort <= 1'b1;
         end else if (fin) begin
            busy <= 1'b0;
         end else if (!busy) begin
            if (q1_st == QS_ACTIVE) begin
               busy  <= 1'b1;
               own   <= 1'b0;
               start <= 1'b1;
               chan  <= cmd1[CH_W-1:0];
            end else if ((q2_st == QS_ACTIVE) && !q1_takes) begin
               busy  <= 1'b1;
               own   <= 1'b1;
               start <= 1'b1;
               chan  <= cmd2[CH_W-1:0];
            end
         end
      end
   end

endmodule

// File: rtl/qcmd_sched.sv
module qcmd_sched
   import qcmd_pkg::*;
#(
   parameter int DEPTH    = 8,
   parameter int CH_W     = 6,
   parameter bit Q2_TIMER = 1'b1,
   localparam int CMD_W = CH_W + 2,
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       q_en,
   input  logic [1:0]       q_cont,
   input  logic [1:0]       ext_trig,
   input  logic [1:0]       sw_trig,
   input  logic             tmr_trig,
   input  logic             cmd_we,
   input  logic             cmd_wq,
   input  logic [IDX_W-1:0] cmd_widx,
   input  logic [CMD_W-1:0] cmd_wdata,
   input  logic             conv_done,
   output logic             conv_start,
   output logic [CH_W-1:0]  conv_chan,
   output logic             conv_abort,
   output logic [1:0]       cf,
   output logic [1:0]       pf,
   output logic [1:0]       tor,
   input  logic [1:0]       clr_cf,
   input  logic [1:0]       clr_pf,
   input  logic [1:0]       clr_tor,
   output logic [3:0]       qstat
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("qcmd_sched: DEPTH must be at least 2");
      end
      if (CH_W < 1) begin : g_bad_chw
         $error("qcmd_sched: CH_W must be at least 1");
      end
   endgenerate

   logic [1:0]       go;
   logic [CMD_W-1:0] cmd1;
   logic [CMD_W-1:0] cmd2;
   logic [IDX_W-1:0] ptr1;
   logic [IDX_W-1:0] ptr2;
   logic [1:0]       set_cf;
   logic [1:0]       set_pf;
   logic [1:0]       set_tor;
   logic [5:0]       flags;
   qstate_e          q1_st;
   qstate_e          q2_st;

   generate
      for (genvar q = 0; q < 2; q++) begin : g_trig
         qcmd_trig #(.HAS_TMR((q == 1) && Q2_TIMER)) u_trig (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (q_en[q]),
            .ext   (ext_trig[q]),
            .sw    (sw_trig[q]),
            .tmr   ((q == 1) ? tmr_trig : 1'b0),
            .go    (go[q])
         );
      end
   endgenerate

   qcmd_store #(.DEPTH(DEPTH), .CMD_W(CMD_W)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (cmd_we),
      .wq     (cmd_wq),
      .widx   (cmd_widx),
      .wdata  (cmd_wdata),
      .rptr1  (ptr1),
      .rptr2  (ptr2),
      .rdata1 (cmd1),
      .rdata2 (cmd2)
   );

   qcmd_seq #(.DEPTH(DEPTH), .CH_W(CH_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go1     (go[0]),
      .go2     (go[1]),
      .cont    (q_cont),
      .done    (conv_done),
      .cmd1    (cmd1),
      .cmd2    (cmd2),
      .ptr1    (ptr1),
      .ptr2    (ptr2),
      .start   (conv_start),
      .chan    (conv_chan),
      .abort   (conv_abort),
      .set_cf  (set_cf),
      .set_pf  (set_pf),
      .set_tor (set_tor),
      .q1_st   (q1_st),
      .q2_st   (q2_st)
   );

   qcmd_flags #(.N(6)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   ({set_tor, set_pf, set_cf}),
      .clr   ({clr_tor, clr_pf, clr_cf}),
      .q     (flags)
   );

   assign cf    = flags[1:0];
   assign pf    = flags[3:2];
   assign tor   = flags[5:4];
   assign qstat = encode_status(q1_st, q2_st);

endmodule

// File: rtl/qcmd_sched_chk.sv
module qcmd_sched_chk
   import qcmd_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       conv_start,
   input logic       conv_abort,
   input logic [1:0] cf,
   input logic [1:0] clr_cf,
   input logic [3:0] qstat,
   input qstate_e    q1_st,
   input qstate_e    q2_st
);
   AST_NEVER_BOTH_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !((q1_st == QS_ACTIVE) && (q2_st == QS_ACTIVE))); // R6

   AST_START_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start); // R2

   AST_ABORT_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
      conv_abort |-> ((q2_st == QS_SUSP) && (q1_st == QS_ACTIVE))); // R6

   AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ((q2_st == QS_PENDING) && (q1_st == QS_ACTIVE)) |=> (q2_st != QS_ACTIVE)); // R7

   AST_CF0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cf[0] && !clr_cf[0]) |=> cf[0]); // R10

   AST_CF1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cf[1] && !clr_cf[1]) |=> cf[1]); // R10

   AST_CODE_0011_BRIEF: assert property (@(posedge clk) disable iff (!rst_n)
      (qstat == 4'b0011) |=> (qstat != 4'b0011)); // R12

   AST_CODE_0111_BRIEF: assert property (@(posedge clk) disable iff (!rst_n)
      (qstat == 4'b0111) |=> (qstat != 4'b0111)); // R12
endmodule

bind qcmd_sched qcmd_sched_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_start (conv_start),
   .conv_abort (conv_abort),
   .cf         (cf),
   .clr_cf     (clr_cf),
   .qstat      (qstat),
   .q1_st      (q1_st),
   .q2_st      (q2_st)
);

// File: tb/qcmd_sched_test.sv
`timescale 1ns/1ps
module qcmd_sched_test;
   localparam int DEPTH = 8;
   localparam int CH_W  = 6;
   localparam int CMD_W = CH_W + 2;
   localparam int IDX_W = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n;
   logic [1:0]       q_en, q_cont, ext_trig, sw_trig;
   logic             tmr_trig, cmd_we, cmd_wq, conv_done;
   logic [IDX_W-1:0] cmd_widx;
   logic [CMD_W-1:0] cmd_wdata;
   logic             conv_start, conv_abort;
   logic [CH_W-1:0]  conv_chan;
   logic [1:0]       cf, pf, tor, clr_cf, clr_pf, clr_tor;
   logic [3:0]       qstat;

   int vectors = 0;
   int errors  = 0;

   always #10 clk = ~clk;

   qcmd_sched #(.DEPTH(DEPTH), .CH_W(CH_W)) uut (
      .clk(clk), .rst_n(rst_n), .q_en(q_en), .q_cont(q_cont),
      .ext_trig(ext_trig), .sw_trig(sw_trig), .tmr_trig(tmr_trig),
      .cmd_we(cmd_we), .cmd_wq(cmd_wq), .cmd_widx(cmd_widx),
      .cmd_wdata(cmd_wdata), .conv_done(conv_done),
      .conv_start(conv_start), .conv_chan(conv_chan), .conv_abort(conv_abort),
      .cf(cf), .pf(pf), .tor(tor), .clr_cf(clr_cf), .clr_pf(clr_pf),
      .clr_tor(clr_tor), .qstat(qstat)
   );

   function automatic logic [CMD_W-1:0] mk(input logic eol, input logic pz,
                                          input int ch);
      return {eol, pz, CH_W'(ch)};
   endfunction

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; q_en = 2'b00; q_cont = 2'b00; ext_trig = 2'b00;
      sw_trig = 2'b00; tmr_trig = 1'b0; cmd_we = 1'b0; cmd_wq = 1'b0;
      cmd_widx = '0; cmd_wdata = '0; conv_done = 1'b0;
      clr_cf = 2'b00; clr_pf = 2'b00; clr_tor = 2'b00;
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic load(input logic q, input int idx, input logic [CMD_W-1:0] w);
      cmd_we = 1'b1; cmd_wq = q; cmd_widx = IDX_W'(idx); cmd_wdata = w;
      tick();
      cmd_we = 1'b0;
   endtask

   task automatic pulse_sw(input int q);
      sw_trig[q] = 1'b1;
      tick();
      sw_trig[q] = 1'b0;
   endtask

   task automatic give_done();
      conv_done = 1'b1;
      tick();
      conv_done = 1'b0;
   endtask

   task automatic expect_start(input string req, input int ch);
      bit seen = 1'b0;
      for (int i = 0; i < 30 && !seen; i++) begin
         if (conv_start) seen = 1'b1;
         else tick();
      end
      chk({req, " start seen"}, int'(seen), 1);
      if (seen) begin
         chk({req, " channel"}, int'(conv_chan), ch);
         tick();
      end
   endtask

   task automatic no_start(input string req, input int n);
      int hits = 0;
      for (int i = 0; i < n; i++) begin
         if (conv_start) hits++;
         tick();
      end
      chk({req, " no start"}, hits, 0);
   endtask

   task automatic t_reset();   // R1
      do_reset();
      chk("R1 qstat", int'(qstat), 0);
      chk("R1 flags", int'({cf, pf, tor}), 0);
      chk("R1 start/abort", int'({conv_start, conv_abort}), 0);
      q_en = 2'b01;
      pulse_sw(0);   // empty slots: channel 0 in each of the DEPTH slots
      for (int i = 0; i < DEPTH; i++) begin
         expect_start("R1 zero slot", 0);
         give_done();
      end
      chk("R1 full-depth pass completes", int'(cf[0]), 1);
   endtask

   task automatic t_walk();    // R2
      do_reset();
      load(0, 0, mk(0, 0, 5)); load(0, 1, mk(0, 0, 6)); load(0, 2, mk(1, 0, 7));
      q_en = 2'b01;
      pulse_sw(0);
      chk("R2 qstat q1 active", int'(qstat), 4'b1000);
      expect_start("R2 first", 5);
      no_start("R2 waits for done", 3);
      give_done(); expect_start("R2 second", 6);
      give_done(); expect_start("R2 third", 7);
      chk("R2 cf before last done", int'(cf[0]), 0);
      give_done();
      chk("R2 cf after end", int'(cf[0]), 1);
      chk("R2 qstat idle", int'(qstat), 0);
      no_start("R2 stops at end", 4);
   endtask

   task automatic t_ext_edge(); // R3
      do_reset();
      load(0, 0, mk(1, 0, 2));
      q_en = 2'b01;
      ext_trig[0] = 1'b1;
      tick();
      expect_start("R3 rising edge", 2);
      give_done();
      no_start("R3 held level", 6);
      chk("R3 no overrun", int'(tor[0]), 0);
      ext_trig[0] = 1'b0; tick();
      ext_trig[0] = 1'b1; tick();
      expect_start("R3 second edge", 2);
      give_done();
      ext_trig[0] = 1'b0;
   endtask

   task automatic t_timer();   // R4
      do_reset();
      load(1, 0, mk(1, 0, 12));
      q_en = 2'b10;
      tmr_trig = 1'b1; tick(); tmr_trig = 1'b0;
      expect_start("R4 timer", 12);
      give_done();
      chk("R4 cf q2", int'(cf[1]), 1);
   endtask

   task automatic t_pause();   // R5
      do_reset();
      load(0, 0, mk(0, 0, 1)); load(0, 1, mk(0, 1, 2)); load(0, 2, mk(1, 0, 3));
      q_en = 2'b01;
      pulse_sw(0);
      expect_start("R5 first", 1); give_done();
      expect_start("R5 paused entry", 2); give_done();
      chk("R5 pf", int'(pf[0]), 1);
      chk("R5 cf clear", int'(cf[0]), 0);
      chk("R5 qstat paused", int'(qstat), 4'b0100);
      no_start("R5 halted", 4);
      pulse_sw(0);
      expect_start("R5 resume next entry", 3); give_done();
      chk("R5 cf after resume", int'(cf[0]), 1);
      chk("R5 qstat idle", int'(qstat), 0);
   endtask

   task automatic t_abort();   // R6, R12
      do_reset();
      load(1, 0, mk(0, 0, 10)); load(1, 1, mk(1, 0, 11));
      load(0, 0, mk(1, 0, 20));
      q_en = 2'b11;
      pulse_sw(1);
      chk("R12 transient 0011", int'(qstat), 4'b0011);
      tick();
      chk("R12 0011 left after one cycle", int'(qstat), 4'b0001);
      expect_start("R6 q2 first", 10);
      pulse_sw(0);
      chk("R6 abort pulse", int'(conv_abort), 1);
      chk("R6 qstat suspended", int'(qstat), 4'b1010);
      expect_start("R6 q1 preempts", 20);
      give_done();
      chk("R6 cf q1", int'(cf[0]), 1);
      chk("R12 resume code 0011", int'(qstat), 4'b0011);
      expect_start("R6 q2 re-executes aborted", 10);
      give_done();
      expect_start("R6 q2 continues", 11);
      give_done();
      chk("R6 cf q2", int'(cf[1]), 1);
      chk("R6 qstat idle", int'(qstat), 0);
   endtask

   task automatic t_pending(); // R7
      do_reset();
      load(0, 0, mk(0, 0, 1)); load(0, 1, mk(1, 0, 2));
      load(1, 0, mk(1, 0, 9));
      q_en = 2'b11;
      pulse_sw(0);
      expect_start("R7 q1 first", 1);
      pulse_sw(1);
      chk("R7 qstat pending", int'(qstat), 4'b1011);
      chk("R7 no abort", int'(conv_abort), 0);
      give_done();
      expect_start("R7 q1 keeps converter", 2);
      give_done();
      expect_start("R7 q2 after q1", 9);
      give_done();
      chk("R7 cf both", int'(cf), 3);
   endtask

   task automatic t_overrun(); // R8
      do_reset();
      load(0, 0, mk(0, 0, 3)); load(0, 1, mk(1, 0, 4));
      q_en = 2'b01;
      pulse_sw(0);
      expect_start("R8 first", 3);
      pulse_sw(0);
      chk("R8 tor q1", int'(tor[0]), 1);
      chk("R8 tor q2 clear", int'(tor[1]), 0);
      give_done();
      expect_start("R8 pass not restarted", 4);
      give_done();
      chk("R8 qstat idle", int'(qstat), 0);
   endtask

   task automatic t_cont();    // R9
      do_reset();
      load(1, 0, mk(0, 0, 7)); load(1, 1, mk(1, 0, 8));
      q_en = 2'b10; q_cont = 2'b10;
      pulse_sw(1);
      expect_start("R9 first", 7); give_done();
      expect_start("R9 second", 8); give_done();
      chk("R9 cf q2", int'(cf[1]), 1);
      expect_start("R9 restart at slot 0", 7);
      chk("R9 no overrun", int'(tor[1]), 0);
      q_cont = 2'b00;
      give_done();
      expect_start("R9 last", 8); give_done();
      chk("R9 qstat idle", int'(qstat), 0);
   endtask

   task automatic t_flags();   // R10
      do_reset();
      load(0, 0, mk(1, 0, 1));
      q_en = 2'b01;
      pulse_sw(0);
      expect_start("R10 pass1", 1); give_done();
      tick(); tick(); tick();
      chk("R10 cf sticky", int'(cf[0]), 1);
      pulse_sw(0);
      expect_start("R10 pass2", 1);
      clr_cf = 2'b01;
      give_done();
      clr_cf = 2'b00;
      chk("R10 set wins over clear", int'(cf[0]), 1);
      clr_cf = 2'b01; tick(); clr_cf = 2'b00;
      chk("R10 cleared", int'(cf[0]), 0);
   endtask

   task automatic t_disabled(); // R11
      do_reset();
      load(0, 0, mk(1, 0, 4));
      q_en = 2'b10;
      pulse_sw(0);
      ext_trig[0] = 1'b1; tick(); ext_trig[0] = 1'b0;
      chk("R11 qstat idle", int'(qstat), 0);
      no_start("R11 disabled q1", 5);
      chk("R11 no flags", int'({cf, pf, tor}), 0);
   endtask

   initial begin : watchdog
      #4ms;
      errors++; vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_walk();
      t_ext_edge();
      t_timer();
      t_pause();
      t_abort();
      t_pending();
      t_overrun();
      t_cont();
      t_flags();
      t_disabled();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule